// File: doc/BRIEF.md
# Bit-Serial Spiking Synapse Unit

This block is one synapse stage in a ring of stages that carries a neuron's membrane potential. The potential travels as a packet of `PKT_W` bits, one bit per clock and least significant bit first. A one-bit frame strobe travels with the data and is high on the first bit of each packet. When no presynaptic spike is pending, the unit passes the stream through a single register stage. When a spike is pending, the unit adds its stored signed weight to the next complete packet with a one-bit serial adder. Because the arithmetic is bit-serial, neighbouring stages in the ring work on different bits of the same packet in the same cycle.

The weight is held in a rotating shift register. Each add rotates it through exactly one full turn, so the weight is unchanged afterwards. The weight is loaded in parallel only while reset is asserted. A spike arms the unit. The add is then applied to the next packet whose strobe arrives, never to a packet already in flight. Several spikes seen before that packet produce a single add.

Top module: `spike_synapse`

## Requirements
- R1: While `rst_n` is low, `den_out` and `frame_out` are 0 one clock later, and every spike seen during reset is discarded.
- R2: With no spike pending, `den_out` equals `den_in` from the previous clock. This adds one cycle of latency to the stream.
- R3: `frame_out` equals `frame_in` from the previous clock.
- R4: After a spike, the next packet whose strobe arrives leaves the unit as (potential + weight) mod 2^`PKT_W`. Both values are sent LSB first, with bit 0 marked by the strobe.
- R5: The weight is two's complement, so a negative weight lowers the potential.
- R6: The adder carry is cleared on bit 0 of each packet, and the carry out of bit `PKT_W`-1 is discarded, giving wraparound.
- R7: The weight is unchanged after an add, so later spikes apply the same value again.
- R8: Several spikes before the next strobe cause exactly one add.
- R9: A spike that arrives while an add is in progress arms the unit for the following packet.
- R10: A spike that arrives on or after the strobe cycle of a packet that is not being modified leaves that packet unchanged. The add goes to the following packet.
- R11: `load_weight` is captured into the weight register only when `rst_n` is low and `load_en` is high. While running, `load_en` has no effect.
- R12: Each add covers exactly `PKT_W` bits. The packet after an add passes through unchanged unless another spike arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Weight load enable; acts only while in reset |
| load_weight | input | PKT_W | Signed weight value to load |
| den_in | input | 1 | Incoming serial potential bit |
| frame_in | input | 1 | High on bit 0 of an incoming packet |
| spike_in | input | 1 | Presynaptic spike |
| den_out | output | 1 | Outgoing serial potential bit, one clock later |
| frame_out | output | 1 | Frame strobe, delayed one clock |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe delay;
- pass-through while the unit is idle;
- that every spike arms the unit;
- that an add runs for exactly one packet length;
- that the weight holds still whenever the unit is idle.

The bench's scenarios are needed for the behaviours that depend on the arithmetic and on timing across packets:
- the numerical sums, including wraparound and a negative weight;
- carry clearing between consecutive adds;
- merging of multiple spikes into one add;
- spikes that land on or inside a packet;
- loads attempted outside reset.

// File: rtl/spike_synapse.sv
module spike_synapse #(
  parameter int PKT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PKT_W-1:0] load_weight,
  input  logic             den_in,
  input  logic             frame_in,
  input  logic             spike_in,
  output logic             den_out,
  output logic             frame_out
);
  localparam int CNT_W = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PKT_W - 1);

  logic [PKT_W-1:0] wgt_q;
  logic             pending_q;
  logic             busy_q;
  logic             carry_q;
  logic [CNT_W-1:0] bit_q;

  wire begin_add = frame_in & pending_q & ~busy_q;
  wire add_now   = begin_add | busy_q;
  wire wbit      = wgt_q[0];
  wire cin       = begin_add ? 1'b0 : carry_q;
  wire sum_bit   = den_in ^ wbit ^ cin;
  wire cout      = (den_in & wbit) | (cin & (den_in ^ wbit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      carry_q   <= 1'b0;
      bit_q     <= '0;
      den_out   <= 1'b0;
      frame_out <= 1'b0;
      if (load_en) wgt_q <= load_weight;
    end else begin
      den_out   <= add_now ? sum_bit : den_in;
      frame_out <= frame_in;
      if (spike_in)       pending_q <= 1'b1;
      else if (begin_add) pending_q <= 1'b0;
      if (add_now) begin
        wgt_q   <= {wbit, wgt_q[PKT_W-1:1]};
        carry_q <= cout;
      end
      if (begin_add) begin
        busy_q <= 1'b1;
        bit_q  <= CNT_W'(1);
      end else if (busy_q) begin
        bit_q <= bit_q + CNT_W'(1);
        if (bit_q == LAST_BIT) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spike_synapse_chk.sv
module spike_synapse_chk #(
  parameter int PKT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             den_in,
  input logic             frame_in,
  input logic             spike_in,
  input logic             den_out,
  input logic             frame_out,
  input logic             pending_q,
  input logic             busy_q,
  input logic [PKT_W-1:0] wgt_q
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= 0;
    else if (busy_q) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  a_r3_frame_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> frame_out == $past(frame_in));

  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !busy_q) |=> den_out == $past(den_in));

  a_r9_spike_arms: assert property (@(posedge clk) disable iff (!rst_n)
    spike_in |=> pending_q);

  a_r12_one_packet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> run_len == PKT_W - 1);

  a_r7_weight_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !busy_q) |=> $stable(wgt_q));
endmodule

bind spike_synapse spike_synapse_chk #(.PKT_W(PKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .den_in(den_in), .frame_in(frame_in),
  .spike_in(spike_in), .den_out(den_out), .frame_out(frame_out),
  .pending_q(pending_q), .busy_q(busy_q), .wgt_q(wgt_q)
);

// File: tb/spike_synapse_bench.sv
module spike_synapse_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_weight = '0;
  logic         den_in = 1'b0;
  logic         frame_in = 1'b0;
  logic         spike_in = 1'b0;
  logic         den_out;
  logic         frame_out;

  spike_synapse #(.PKT_W(W)) u_spike_synapse (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_weight(load_weight),
    .den_in(den_in), .frame_in(frame_in), .spike_in(spike_in),
    .den_out(den_out), .frame_out(frame_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic         spk;
    logic [W-1:0] pot;
    logic [W-1:0] exp;
  } vec_t;

  // weight 0x123 for the whole table
  localparam vec_t TABLE [8] = '{
    '{1'b0, 32'h12345678, 32'h12345678},  // R2 idle, spike in reset dropped (R1)
    '{1'b1, 32'h12345678, 32'h1234579B},  // R4
    '{1'b0, 32'hDEADBEEF, 32'hDEADBEEF},  // R12 disarmed afterwards
    '{1'b1, 32'hFFFFFFFF, 32'h00000122},  // R6 wrap
    '{1'b1, 32'h00000000, 32'h00000123},  // R6 carry cleared, R7 weight kept
    '{1'b0, 32'h0F0F0F0F, 32'h0F0F0F0F},  // R2
    '{1'b1, 32'h7FFFFEDD, 32'h80000000},  // R6
    '{1'b1, 32'hA5A5A5A5, 32'hA5A5A6C8}   // R7
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] pot, input int spike_at, output logic [W-1:0] res);
    res = '0;
    for (int i = 0; i <= W; i++) begin
      @(negedge clk);
      if (i > 0) res[i-1] = den_out;
      if (i == 1) check("R3 frame_out", {{(W-1){1'b0}}, frame_out}, 1);
      if (i < W) begin
        den_in   = pot[i];
        frame_in = (i == 0);
      end else begin
        den_in   = 1'b0;
        frame_in = 1'b0;
      end
      spike_in = (i == spike_at);
    end
  endtask

  task automatic pulse();
    @(negedge clk) spike_in = 1'b1;
    @(negedge clk) spike_in = 1'b0;
  endtask

  task automatic do_reset(input logic [W-1:0] w);
    @(negedge clk);
    rst_n = 1'b0; load_en = 1'b1; load_weight = w;
    den_in = 1'b1; frame_in = 1'b1; spike_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 den_out in reset", {{(W-1){1'b0}}, den_out}, 0);
    check("R1 frame_out in reset", {{(W-1){1'b0}}, frame_out}, 0);
    load_en = 1'b0; den_in = 1'b0; frame_in = 1'b0; spike_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; load_weight = 32'h5555AAAA;
  endtask

  initial begin
    logic [W-1:0] r;
    do_reset(32'h00000123);
    for (int v = 0; v < 8; v++) begin
      if (TABLE[v].spk) pulse();
      send(TABLE[v].pot, -1, r);
      check(TABLE[v].spk ? "R4 table add" : "R2 table pass", r, TABLE[v].exp);
    end

    do_reset(32'hFFFFFFF6);
    pulse();
    send(32'd100, -1, r);
    check("R5 negative weight", r, 32'd90);

    @(negedge clk) load_en = 1'b1; load_weight = 32'h00001000;
    @(negedge clk) load_en = 1'b0;
    pulse();
    send(32'd100, -1, r);
    check("R11 load ignored while running", r, 32'd90);

    pulse(); pulse(); pulse();
    send(32'd0, -1, r);
    check("R8 merged spikes add once", r, 32'hFFFFFFF6);
    send(32'd0, -1, r);
    check("R8 no second add", r, 32'd0);

    send(32'd50, 0, r);
    check("R10 spike on strobe ignored", r, 32'd50);
    send(32'd50, -1, r);
    check("R10 add on following packet", r, 32'd40);

    send(32'd7, 10, r);
    check("R10 spike mid-packet ignored", r, 32'd7);
    send(32'd7, -1, r);
    check("R10 add after mid-packet spike", r, 32'hFFFFFFFD);

    pulse();
    send(32'd20, 5, r);
    check("R9 first add", r, 32'd10);
    send(32'd20, -1, r);
    check("R9 spike during add rearms", r, 32'd10);
    send(32'd20, -1, r);
    check("R12 disarmed after add", r, 32'd20);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule